// File: doc/BRIEF.md
# Set/Clear Clock Gate Register Bank

This block holds one enable bit for each of a parameterised number of clock branches and lets software change them without a read-modify-write sequence. A small memory-mapped port exposes three word registers. One word turns gates on, where every bit written as 1 turns its gate on. A second word turns gates off in the same way. A third, read-only word shows the live on/off state of every gate. Because a write touches only the bits written as 1, two agents can change different gates without a lock.

Each status bit drives a gate-enable output for its own clock branch. That enable passes through a two-stage synchroniser clocked by the branch clock, followed by a final stage that updates on the falling edge. As a result, an enable level presented to a downstream AND-style gate only moves while that branch clock is low, so the gated clock never produces a runt pulse. Every gate comes out of reset in a configured state, which is set by a parameter vector.

Top module: `clk_gate_bank`

## Requirements
- R1: While and after reset, the state word and every `gateEn` bit equal the `GATE_INIT` parameter.
- R2: A write to byte address 0x4 turns on each gate whose data bit is 1. Gates whose data bit is 0 keep their state.
- R3: A write to byte address 0x8 turns off each gate whose data bit is 1. Gates whose data bit is 0 keep their state.
- R4: A read of byte address 0x0 returns gate i's current state in data bit i, with all bits at or above `NUM_GATES` read as zero. The read is combinational and reflects every write taken on an earlier clock edge.
- R5: A write to address 0x0 changes no gate.
- R6: Reads of addresses 0x4 and 0x8 return zero.
- R7: Every other address returns zero on a read, and a write to it changes no gate. This includes 0xC and any address that is not one of the three word offsets.
- R8: Write data bits at positions `NUM_GATES` and above have no effect on any gate.
- R9: After the state bit of gate i changes, `gateEn[i]` takes the new value within three cycles of `branchClk[i]`.
- R10: `gateEn[i]` changes only while `branchClk[i]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| regAddr | input | ADDR_W | Byte address within the bank |
| regWrEn | input | 1 | Write strobe, taken on the rising edge of clk |
| regWrData | input | DATA_W | Write data, one bit per gate |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| branchClk | input | NUM_GATES | Clock of each gated branch |
| gateEn | output | NUM_GATES | Per-branch enable, synchronised to its branch clock |

## Verification
A corrupted state bit shows up on the state word at the first read after the write that caused it. The same error reaches `gateEn` a few branch-clock cycles later. The bench therefore reads the state word after every write and checks each enable after enough branch cycles to cross the synchroniser. A decode fault behaves differently: a write lands on the wrong word, or a non-state address reads back nonzero. Either fault appears on the very next read. An enable that moves on the wrong clock phase is caught at the instant it changes, because the bench samples the level of the branch clock at that moment.

// File: rtl/clk_gate_bank_pkg.sv
package clk_gate_bank_pkg;

  // Byte offsets of the three words; software relies on these positions.
  localparam int unsigned STATE_OFS = 0;
  localparam int unsigned ON_OFS    = 4;
  localparam int unsigned OFF_OFS   = 8;

  // Strobes passed from the decoder to the state datapath.
  typedef struct packed {
    logic stateSel;  // address selects the state word (read path)
    logic onStb;     // write to the turn-on word
    logic offStb;    // write to the turn-off word
  } gateStrobe_t;

endpackage

// File: rtl/gate_bank_ctrl.sv
module gate_bank_ctrl
  import clk_gate_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output gateStrobe_t       strobes
);

  localparam logic [ADDR_W-1:0] StateAddr = ADDR_W'(STATE_OFS);
  localparam logic [ADDR_W-1:0] OnAddr    = ADDR_W'(ON_OFS);
  localparam logic [ADDR_W-1:0] OffAddr   = ADDR_W'(OFF_OFS);

  logic hitState, hitOn, hitOff;

  always_comb begin
    hitState = (regAddr == StateAddr);
    hitOn    = (regAddr == OnAddr);
    hitOff   = (regAddr == OffAddr);
    strobes.stateSel = hitState;
    strobes.onStb    = regWrEn && hitOn;
    strobes.offStb   = regWrEn && hitOff;
  end

  // R7: a single address never raises two decode hits
  decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.stateSel, strobes.onStb, strobes.offStb}));

endmodule

// File: rtl/gate_bank_dpath.sv
module gate_bank_dpath
  import clk_gate_bank_pkg::*;
#(
  parameter int unsigned              NUM_GATES = 8,
  parameter int unsigned              DATA_W    = 32,
  parameter logic [NUM_GATES-1:0]     GATE_INIT = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobe_t          strobes,
  input  logic [NUM_GATES-1:0] wrMask,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_GATES-1:0] gateState
);

  logic [NUM_GATES-1:0] stateNext;
  logic [NUM_GATES-1:0] onBits, offBits;

  always_comb begin
    onBits  = strobes.onStb  ? wrMask : '0;
    offBits = strobes.offStb ? wrMask : '0;
    // turn-off wins should both ever be presented together
    stateNext = (gateState | onBits) & ~offBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateState <= GATE_INIT;
    else       gateState <= stateNext;
  end

  always_comb begin
    rdData = '0;
    if (strobes.stateSel) rdData[NUM_GATES-1:0] = gateState;
  end

  // R2
  on_bits_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.onStb |=> ((gateState & $past(wrMask)) == $past(wrMask)));

  // R3
  off_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.offStb |=> ((gateState & $past(wrMask)) == '0));

  // R2 R3: bits written as zero keep their state
  zero_bits_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.onStb || strobes.offStb) |=>
      ((gateState & ~$past(wrMask)) == ($past(gateState) & ~$past(wrMask))));

  // R5 R7: no write strobe, no change
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.onStb && !strobes.offStb) |=> $stable(gateState));

endmodule

// File: rtl/gate_sync.sv
module gate_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        INIT_BIT = 1'b0
) (
  input  logic brClk,
  input  logic rstN,
  input  logic dIn,
  output logic gOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge brClk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{INIT_BIT}};
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  // final stage moves on the falling edge, so it only changes while brClk is low
  always_ff @(negedge brClk or negedge rstN) begin
    if (!rstN) gOut <= INIT_BIT;
    else       gOut <= chain[STAGES-1];
  end

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
  import clk_gate_bank_pkg::*;
#(
  parameter int unsigned          NUM_GATES   = 8,
  parameter int unsigned          DATA_W      = 32,
  parameter int unsigned          ADDR_W      = 4,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter logic [NUM_GATES-1:0] GATE_INIT   = 8'h35
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [NUM_GATES-1:0] branchClk,
  output logic [NUM_GATES-1:0] gateEn
);

  gateStrobe_t          strobes;
  logic [NUM_GATES-1:0] gateState;

  // R8: only the low NUM_GATES data bits reach the state
  if (DATA_W > NUM_GATES) begin : g_hiBits
    logic unusedHiBits;
    assign unusedHiBits = ^regWrData[DATA_W-1:NUM_GATES];
  end

  gate_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  gate_bank_dpath #(
    .NUM_GATES (NUM_GATES),
    .DATA_W    (DATA_W),
    .GATE_INIT (GATE_INIT)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrMask    (regWrData[NUM_GATES-1:0]),
    .rdData    (regRdData),
    .gateState (gateState)
  );

  for (genvar i = 0; i < NUM_GATES; i++) begin : g_branch
    gate_sync #(
      .STAGES   (SYNC_STAGES),
      .INIT_BIT (GATE_INIT[i])
    ) u_sync (
      .brClk (branchClk[i]),
      .rstN  (rstN),
      .dIn   (gateState[i]),
      .gOut  (gateEn[i])
    );
  end

endmodule

// File: tb/clk_gate_bank_test.sv
`timescale 1ns/1ps
module clk_gate_bank_test;

  localparam int unsigned NG = 8;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam logic [NG-1:0] INIT = 8'h35;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [NG-1:0] branchClk = '0;
  logic [NG-1:0] gateEn;

  int compared = 0;
  int mismatched = 0;
  logic [NG-1:0] model = INIT;
  logic rdStrobe = 1'b0;
  logic [DW-1:0] expQ[$];
  string tagQ[$];

  clk_gate_bank #(.NUM_GATES(NG), .DATA_W(DW), .ADDR_W(AW), .GATE_INIT(INIT)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .branchClk(branchClk), .gateEn(gateEn));

  always #10 clk = ~clk;

  for (genvar i = 0; i < NG; i++) begin : g_bclk
    initial begin
      #(3 + i);
      forever #(5 + 2 * i) branchClk[i] = ~branchClk[i];
    end
    // R10 monitor: every enable change must happen with its branch clock low
    always @(gateEn[i]) begin
      if (rstN) begin
        compared++;
        if (branchClk[i] !== 1'b0) begin
          mismatched++;
          $display("FAIL R10 gate %0d changed with branchClk=%b expected 0", i, branchClk[i]);
        end
      end
    end
  end

  function automatic logic [DW-1:0] stateWord();
    logic [DW-1:0] w = '0;
    w[NG-1:0] = model;
    return w;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(logic [AW-1:0] a, logic [DW-1:0] d);
    @(posedge clk); #2;
    rdStrobe = 1'b0; regAddr = a; regWrData = d; regWrEn = 1'b1;
    if (a == 4'h4)      model = model | d[NG-1:0];
    else if (a == 4'h8) model = model & ~d[NG-1:0];
  endtask

  // driver: pushes the expected read value, the monitor compares it
  task automatic readReg(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(posedge clk); #2;
    regWrEn = 1'b0; regAddr = a; rdStrobe = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic idle(int n);
    @(posedge clk); #2;
    regWrEn = 1'b0; rdStrobe = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic gateCheck(string tag);
    idle(10);
    check(tag, DW'(gateEn), DW'(model));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rdStrobe && expQ.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, regRdData, e);
    end
  end

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #55;
    check("R1 gateEn during reset", DW'(gateEn), DW'(INIT));
    rstN = 1'b1;
    readReg(4'h0, DW'(INIT), "R1 R4 state after reset");
    gateCheck("R1 gateEn after reset");

    writeReg(4'h4, 32'h0000_00C2);
    readReg(4'h0, stateWord(), "R2 turn on C2");
    gateCheck("R9 after turn on");

    writeReg(4'h8, 32'h0000_0021);
    readReg(4'h0, stateWord(), "R3 turn off 21");
    gateCheck("R9 after turn off");

    writeReg(4'h4, 32'h0);
    readReg(4'h0, stateWord(), "R2 zero data no change");

    writeReg(4'h0, 32'hFFFF_FFFF);
    readReg(4'h0, stateWord(), "R5 state write ignored");

    readReg(4'h4, 32'h0, "R6 turn-on word reads zero");
    readReg(4'h8, 32'h0, "R6 turn-off word reads zero");

    writeReg(4'hC, 32'hFFFF_FFFF);
    readReg(4'hC, 32'h0, "R7 unmapped 0xC reads zero");
    readReg(4'h0, stateWord(), "R7 write to 0xC ignored");
    writeReg(4'h9, 32'hFFFF_FFFF);
    writeReg(4'h5, 32'hFFFF_FFFF);
    readReg(4'h0, stateWord(), "R7 unaligned writes ignored");
    readReg(4'h1, 32'h0, "R7 unaligned read zero");

    writeReg(4'h4, 32'hFFFF_FF00);
    readReg(4'h0, stateWord(), "R8 high data bits ignored");

    writeReg(4'h8, 32'hFFFF_FFFF);
    readReg(4'h0, 32'h0, "R3 all off");
    gateCheck("R9 all off");

    writeReg(4'h4, 32'h0000_00FF);
    readReg(4'h0, 32'h0000_00FF, "R2 R4 all on");
    gateCheck("R9 all on");

    writeReg(4'h8, 32'h0000_0055);
    writeReg(4'h4, 32'h0000_0011);
    readReg(4'h0, stateWord(), "R2 R3 back to back");
    gateCheck("R9 back to back");

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule